// File: doc/BRIEF.md
# Multiplexed-Bus Memory Glue Controller

This block is the glue between a 16-bit processor whose address and data share one set of bus lines and the memories beside it. The processor marks the address phase with a row strobe and the data phase with a column strobe, both active low. On the falling edge of the row strobe the block captures the address from the shared bus into its own register. That captured address feeds the memory chips and a window decoder. The decoder picks out a ROM window at the top of the address space and a RAM window at the bottom.

From the decoded window, the two strobes and the read/write and byte-select inputs, the block forms one ROM output enable and separate output and write enables for the high and low RAM byte lanes. A strobe pair without the column strobe, as in an interrupt-acknowledge cycle, enables nothing. The processor reads a location before every write to it, and that read never produces a write enable.

While the processor holds its bus-clear input active and power is reported good, the block places the startup mode word on the shared bus. It drives low only the bits that must read as zero. Bus pull-ups supply the ones.

Top module: `glue_bus_ctrl`

## Requirements
- R1: With `bclr_n` low and `pwr_ok` high for at least SYNC_STAGES (2) rising clock edges, every bus bit that is 0 in MODE_WORD (default 16'hF3A5) is driven low and every bit that is 1 is left high-impedance, so the bus reads MODE_WORD through pull-ups.
- R2: The block drives no bus line while `pwr_ok` is low or while `bclr_n` is high.
- R3: `mem_addr` takes the bus value at the falling edge of `ras_n` and holds it through bus changes until the next falling edge. Reset clears it to 0.
- R4: `rom_oe_n` is low only when `ras_n` and `cas_n` are both low, `rw` is 1 (read) and `mem_addr` lies in [ROM_BASE, ROM_BASE+ROM_SIZE), by default 16'hE000 to 16'hFFFF. The ROM never receives a write enable.
- R5: A read (`rw`=1) in the RAM window [RAM_BASE, RAM_BASE+RAM_SIZE), by default 16'h0000 to 16'h7FFF, drives both `ram_oe_hi_n` and `ram_oe_lo_n` low while both strobes are low, whatever the value of `bsel`.
- R6: A write (`rw`=0) in the RAM window asserts both write enables for a word (`bsel`=0). For a byte (`bsel`=1) it asserts only `ram_we_lo_n` when `mem_addr[0]`=0 and only `ram_we_hi_n` when `mem_addr[0]`=1.
- R7: An address outside both windows asserts no enable.
- R8: With `cas_n` high, no enable is asserted even while `ras_n` is low, as in an interrupt-acknowledge cycle.
- R9: A read cycle never asserts either RAM write enable, so the read that precedes each write has no side effect.
- R10: All memory enables are inactive whenever `ras_n` is high or `bclr_n` is low. The mode-word driver, the ROM output and the RAM outputs are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the power-good synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-up status, high when supply is valid (asynchronous) |
| bclr_n | input | 1 | Processor bus-clear, active low |
| ras_n | input | 1 | Row (address) strobe, active low |
| cas_n | input | 1 | Column (data) strobe, active low |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bsel | input | 1 | 1 = byte transfer, 0 = word transfer |
| dal | inout | 16 | Multiplexed address/data bus |
| mem_addr | output | 16 | Captured address for the memories |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_hi_n | output | 1 | RAM high-byte output enable, active low |
| ram_oe_lo_n | output | 1 | RAM low-byte output enable, active low |
| ram_we_hi_n | output | 1 | RAM high-byte write enable, active low |
| ram_we_lo_n | output | 1 | RAM low-byte write enable, active low |

## Verification
The decode is tried with word and byte cycles at even and odd addresses, reads and writes at both edges of each window, the gap between the windows and a write aimed at the ROM. These patterns separate lane selection from window selection and from read/write qualification. A strobe pair without the column strobe shows that the interrupt-acknowledge case stays silent. Changing the bus while the row strobe stays low shows that capture is edge-based and not transparent. The mode-word tests move power-good and bus-clear one at a time, including a row strobe during bus-clear, which tells the pull-up/drive-low pattern apart from any contention with the memory enables.

// File: rtl/glue_pkg.sv
package glue_pkg;

  // Decoded window membership of the captured address.
  typedef struct packed {
    logic rom_hit;
    logic ram_hit;
  } win_t;

  // Active-high enable set, converted to active low at the top.
  typedef struct packed {
    logic rom_oe;
    logic oe_hi;
    logic oe_lo;
    logic we_hi;
    logic we_lo;
  } ena_t;

  // True when addr lies in [base, base+size).
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (addr >= base) && ((addr - base) < size);
  endfunction

  // Byte lanes touched by a cycle: {hi, lo}.
  // Reads and word transfers use both lanes; a byte write picks one by addr bit 0.
  function automatic logic [1:0] lane_mask(input logic is_read,
                                           input logic is_byte,
                                           input logic addr_lsb);
    if (is_read || !is_byte) return 2'b11;
    return addr_lsb ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/glue_pwr_sync.sv
module glue_pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/glue_addr_latch.sv
module glue_addr_latch #(
  parameter int W = 16
) (
  input  logic         rst_n,
  input  logic         ras_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] addr_q
);
  // Edge-triggered capture clocked by the inverted row strobe.
  logic row_clk;
  assign row_clk = ~ras_n;

  always_ff @(posedge row_clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= bus_in;
  end
endmodule

// File: rtl/glue_window_dec.sv
module glue_window_dec
  import glue_pkg::*;
#(
  parameter int          W        = 16,
  parameter logic [31:0] ROM_BASE = 32'h0000_E000,
  parameter logic [31:0] ROM_SIZE = 32'h0000_2000,
  parameter logic [31:0] RAM_BASE = 32'h0000_0000,
  parameter logic [31:0] RAM_SIZE = 32'h0000_8000
) (
  input  logic [W-1:0] addr,
  output win_t         win
);
  logic [31:0] addr_ext;
  assign addr_ext    = 32'(addr);
  assign win.rom_hit = in_window(addr_ext, ROM_BASE, ROM_SIZE);
  assign win.ram_hit = in_window(addr_ext, RAM_BASE, RAM_SIZE);
endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen
  import glue_pkg::*;
(
  input  logic ras_n,
  input  logic cas_n,
  input  logic bclr_n,
  input  logic rw,
  input  logic bsel,
  input  logic addr_lsb,
  input  win_t win,
  output ena_t ena
);
  logic       data_phase;
  logic [1:0] lanes;

  // A memory data phase needs both strobes and the bus not cleared.
  assign data_phase = ~ras_n & ~cas_n & bclr_n;
  assign lanes      = lane_mask(rw, bsel, addr_lsb);

  always_comb begin
    ena        = '0;
    ena.rom_oe = data_phase & rw & win.rom_hit;
    ena.oe_hi  = data_phase & rw & win.ram_hit & lanes[1];
    ena.oe_lo  = data_phase & rw & win.ram_hit & lanes[0];
    ena.we_hi  = data_phase & ~rw & win.ram_hit & lanes[1];
    ena.we_lo  = data_phase & ~rw & win.ram_hit & lanes[0];
  end
endmodule

// File: rtl/glue_bus_ctrl.sv
module glue_bus_ctrl
  import glue_pkg::*;
#(
  parameter int          W           = 16,
  parameter logic [15:0] MODE_WORD   = 16'hF3A5,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] ROM_BASE    = 32'h0000_E000,
  parameter logic [31:0] ROM_SIZE    = 32'h0000_2000,
  parameter logic [31:0] RAM_BASE    = 32'h0000_0000,
  parameter logic [31:0] RAM_SIZE    = 32'h0000_8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_ok,
  input  logic         bclr_n,
  input  logic         ras_n,
  input  logic         cas_n,
  input  logic         rw,
  input  logic         bsel,
  inout  wire  [W-1:0] dal,
  output logic [W-1:0] mem_addr,
  output logic         rom_oe_n,
  output logic         ram_oe_hi_n,
  output logic         ram_oe_lo_n,
  output logic         ram_we_hi_n,
  output logic         ram_we_lo_n
);
  logic pwr_sync;
  logic mode_active;
  win_t win;
  ena_t ena;

  glue_pwr_sync #(.STAGES(SYNC_STAGES)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pwr_ok),
    .sync_out (pwr_sync)
  );

  // Mode word goes out only in bus-clear with power good (raw and synchronized).
  assign mode_active = ~bclr_n & pwr_ok & pwr_sync;

  for (genvar i = 0; i < W; i++) begin : g_mode
    if (i < 16 && !MODE_WORD[i % 16]) begin : g_low
      assign dal[i] = mode_active ? 1'b0 : 1'bz;
    end
  end

  glue_addr_latch #(.W(W)) u_latch (
    .rst_n  (rst_n),
    .ras_n  (ras_n),
    .bus_in (dal),
    .addr_q (mem_addr)
  );

  glue_window_dec #(
    .W(W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
  ) u_dec (
    .addr (mem_addr),
    .win  (win)
  );

  glue_strobe_gen u_strb (
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .bclr_n   (bclr_n),
    .rw       (rw),
    .bsel     (bsel),
    .addr_lsb (mem_addr[0]),
    .win      (win),
    .ena      (ena)
  );

  assign rom_oe_n    = ~ena.rom_oe;
  assign ram_oe_hi_n = ~ena.oe_hi;
  assign ram_oe_lo_n = ~ena.oe_lo;
  assign ram_we_hi_n = ~ena.we_hi;
  assign ram_we_lo_n = ~ena.we_lo;
endmodule

// File: rtl/glue_bus_chk.sv
module glue_bus_chk #(
  parameter int          W        = 16,
  parameter logic [31:0] ROM_BASE = 32'h0000_E000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_ok,
  input logic         bclr_n,
  input logic         ras_n,
  input logic         cas_n,
  input logic         rw,
  input logic         bsel,
  input logic         mode_active,
  input logic [W-1:0] mem_addr,
  input logic         rom_oe_n,
  input logic         ram_oe_hi_n,
  input logic         ram_oe_lo_n,
  input logic         ram_we_hi_n,
  input logic         ram_we_lo_n
);
  logic any_ram_oe;
  assign any_ram_oe = ~ram_oe_hi_n | ~ram_oe_lo_n;

  AST_MODE_IN_BCLR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_active |-> !bclr_n);                                             // R1
  AST_NO_DRIVE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !mode_active);                                            // R2
  AST_ROM_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (!ras_n && !cas_n && rw));                              // R4
  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> (32'(mem_addr) >= ROM_BASE));                           // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw && bsel) |-> (ram_we_hi_n || ram_we_lo_n));                      // R6
  AST_NO_CAS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |-> (rom_oe_n && !any_ram_oe && ram_we_hi_n && ram_we_lo_n));   // R8
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> (ram_we_hi_n && ram_we_lo_n));                                 // R9
  AST_RAS_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n || !bclr_n) |-> (rom_oe_n && !any_ram_oe && ram_we_hi_n && ram_we_lo_n)); // R10
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mode_active, ~rom_oe_n, any_ram_oe}) <= 1);               // R10
endmodule

bind glue_bus_ctrl glue_bus_chk #(.W(W), .ROM_BASE(ROM_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .bclr_n      (bclr_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .rw          (rw),
  .bsel        (bsel),
  .mode_active (mode_active),
  .mem_addr    (mem_addr),
  .rom_oe_n    (rom_oe_n),
  .ram_oe_hi_n (ram_oe_hi_n),
  .ram_oe_lo_n (ram_oe_lo_n),
  .ram_we_hi_n (ram_we_hi_n),
  .ram_we_lo_n (ram_we_lo_n)
);

// File: tb/tb_glue_bus_ctrl.sv
module tb_glue_bus_ctrl;
  localparam logic [15:0] MODE = 16'hF3A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic bclr_n = 1'b1;
  logic ras_n = 1'b1;
  logic cas_n = 1'b1;
  logic rw = 1'b1;
  logic bsel = 1'b0;
  logic drv_en = 1'b0;
  logic [15:0] drv_val = '0;
  wire  [15:0] dal;
  logic [15:0] mem_addr;
  logic rom_oe_n, ram_oe_hi_n, ram_oe_lo_n, ram_we_hi_n, ram_we_lo_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign dal = drv_en ? drv_val : 16'bz;
  for (genvar i = 0; i < 16; i++) begin : g_pu
    pullup pu (dal[i]);
  end

  glue_bus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bclr_n(bclr_n),
    .ras_n(ras_n), .cas_n(cas_n), .rw(rw), .bsel(bsel), .dal(dal),
    .mem_addr(mem_addr), .rom_oe_n(rom_oe_n), .ram_oe_hi_n(ram_oe_hi_n),
    .ram_oe_lo_n(ram_oe_lo_n), .ram_we_hi_n(ram_we_hi_n), .ram_we_lo_n(ram_we_lo_n)
  );

  // Expected enables, active high: {rom_oe, oe_hi, oe_lo, we_hi, we_lo}
  typedef struct packed {
    logic [15:0] addr;
    logic        rd;
    logic        byt;
    logic        cas;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b1, 1'b0, 1'b1, 5'b01100},  // R5 word read
    '{16'h0101, 1'b1, 1'b1, 1'b1, 5'b01100},  // R5 byte read, both lanes
    '{16'h0200, 1'b0, 1'b0, 1'b1, 5'b00011},  // R6 word write
    '{16'h0200, 1'b0, 1'b1, 1'b1, 5'b00001},  // R6 byte write even -> low
    '{16'h0201, 1'b0, 1'b1, 1'b1, 5'b00010},  // R6 byte write odd -> high
    '{16'hE000, 1'b1, 1'b0, 1'b1, 5'b10000},  // R4 ROM lower edge
    '{16'hFFFE, 1'b1, 1'b0, 1'b1, 5'b10000},  // R4 ROM upper edge
    '{16'hDFFE, 1'b1, 1'b0, 1'b1, 5'b00000},  // R7 gap below ROM
    '{16'h8000, 1'b0, 1'b0, 1'b1, 5'b00000},  // R7 just above RAM, write
    '{16'hE000, 1'b0, 1'b0, 1'b1, 5'b00000},  // R4 no write into ROM
    '{16'h7FFF, 1'b0, 1'b1, 1'b1, 5'b00010},  // R6 RAM top odd byte
    '{16'h0100, 1'b1, 1'b0, 1'b0, 5'b00000},  // R8 no CAS (ack cycle)
    '{16'h0200, 1'b1, 1'b1, 1'b1, 5'b01100}   // R9 read before write: no WE
  };

  function automatic logic [4:0] enables();
    return ~{rom_oe_n, ram_oe_hi_n, ram_oe_lo_n, ram_we_hi_n, ram_we_lo_n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Address phase, then data phase, then check; strobes released after.
  task automatic bus_cycle(input logic [15:0] a, input logic rd, input logic byt,
                           input logic use_cas, input logic [15:0] late_bus,
                           input logic change_bus);
    @(negedge clk);
    drv_en = 1'b1; drv_val = a; rw = rd; bsel = byt; ras_n = 1'b0;
    @(negedge clk);
    if (change_bus) drv_val = late_bus;
    else            drv_en = 1'b0;
    cas_n = ~use_cas;
    @(negedge clk);
  endtask

  task automatic end_cycle();
    ras_n = 1'b1; cas_n = 1'b1; drv_en = 1'b0;
    #1;
    check("R10 enables off with RAS high", 32'(enables()), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R3 reset address", 32'(mem_addr), 32'h0);
    check("R10 reset enables", 32'(enables()), 32'h0);
    check("R2 bus idle at reset", 32'(dal), 32'hFFFF);
    rst_n = 1'b1;

    // Table walk over decode vectors (R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < NV; k++) begin
      bus_cycle(VECS[k].addr, VECS[k].rd, VECS[k].byt, VECS[k].cas, 16'h0, 1'b0);
      #1;
      check($sformatf("R4/R5/R6/R7/R8/R9 vector %0d enables", k),
            32'(enables()), 32'(VECS[k].exp));
      check($sformatf("R3 vector %0d captured address", k),
            32'(mem_addr), 32'(VECS[k].addr));
      end_cycle();
    end

    // R3: bus changes while RAS stays low must not alter the captured address
    bus_cycle(16'h0100, 1'b1, 1'b0, 1'b1, 16'hE002, 1'b1);
    #1;
    check("R3 hold under low RAS", 32'(mem_addr), 32'h0100);
    check("R5 decode uses held address", 32'(enables()), 32'b01100);
    end_cycle();
    drv_en = 1'b1; drv_val = 16'hE004;
    #5;
    check("R3 hold with RAS high", 32'(mem_addr), 32'h0100);
    drv_en = 1'b0;

    // R2: bus-clear without power good drives nothing
    @(negedge clk);
    bclr_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R2 no drive before power good", 32'(dal), 32'hFFFF);

    // R1: power good, after the synchronizer, mode word appears
    pwr_ok = 1'b1;
    @(negedge clk);
    #1;
    check("R1 not yet driven one edge after power good", 32'(dal), 32'hFFFF);
    repeat (2) @(negedge clk);
    #1;
    check("R1 mode word on bus", 32'(dal), 32'(MODE));

    // R10: row/column strobes during bus-clear enable no memory
    rw = 1'b1; bsel = 1'b0;
    ras_n = 1'b0;
    @(negedge clk);
    cas_n = 1'b0;
    @(negedge clk);
    #1;
    check("R3 captured mode word", 32'(mem_addr), 32'(MODE));
    check("R10 no memory enable in bus-clear", 32'(enables()), 32'h0);
    ras_n = 1'b1; cas_n = 1'b1;

    // R2: power drop releases immediately
    @(negedge clk);
    pwr_ok = 1'b0;
    #1;
    check("R2 release on power loss", 32'(dal), 32'hFFFF);
    pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 mode word back", 32'(dal), 32'(MODE));

    // R2: leaving bus-clear releases the bus
    bclr_n = 1'b1;
    #1;
    check("R2 release on bus-clear end", 32'(dal), 32'hFFFF);

    // Normal cycle afterwards still works (R4)
    bus_cycle(16'hF000, 1'b1, 1'b0, 1'b1, 16'h0, 1'b0);
    #1;
    check("R4 ROM read after bus-clear", 32'(enables()), 32'b10000);
    end_cycle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule